// File: doc/BRIEF.md
# Periodic Peripheral Power Event Scheduler

This block switches groups of peripheral enable lines on and off once per programmable period with no processor involvement. A period counter, advanced through a prescaler, produces the first event of each period (Start 1). That event launches an unprescaled offset counter, and three further events are timed against it: End 1, Start 2 and End 2. Start events set the enable bits selected by their own mask. End events clear the bits selected by theirs. End 2 also halts and zeroes the offset counter until the next Start 1.

Within the mask, one bit is the analog enable of a converter and another is its digital enable. A start event whose mask contains the digital converter bit also gives a one-cycle conversion trigger. Software programs the block through a write-only register port. The programmed values are staged and only become active at the next period boundary, or at once while the block is disabled.

Top module: `pwr_evt_sched`

## Requirements
- R1: While rst_ni is low, and on the cycle after any cycle in which en_i is low, periph_en_o is all zero and conv_trig_o is 0. Both counters are held at zero while en_i is low.
- R2: Counting starts when en_i rises. The prescaler makes the period counter advance once every PRESCALE+1 clocks, and the counter wraps from PERIOD to 0. One period therefore lasts (PRESCALE+1)*(PERIOD+1) clocks.
- R3: Number the first rising edge with en_i high as edge 1. Start 1 fires on edge (PRESCALE+1)*S1+1, and again one period later for as long as the block stays enabled. Its mask bits show on periph_en_o after that edge.
- R4: Start 1 zeroes the offset counter and starts it, and the counter then advances on every clock. An event programmed with offset value v applies its mask after edge s+1+v, where s is the Start 1 edge.
- R5: Start 1 and Start 2 set their mask bits. End 1 and End 2 clear their mask bits. If a bit is set and cleared on the same edge, it ends up cleared.
- R6: End 2 stops the offset counter and resets it to zero. Any End 1 or Start 2 whose value is greater than E2 does not fire in that period.
- R7: When E1 equals E2, both clear masks are applied on the same edge.
- R8: A Start 1 match that comes while the offset counter is still running is ignored, together with the later events of that period. This happens when E2 >= (PRESCALE+1)*(PERIOD+1)-1 with S1=0.
- R9: Mask bit 6 is the converter analog enable and bit 7 is the converter digital enable (ADCD_BIT). A start event whose mask has bit 7 set drives conv_trig_o high for exactly the cycle after that event's edge.
- R10: Register addresses are: 0 PRESCALE, 1 PERIOD, 2 S1, 3 E1, 4 S2, 5 E2, 6 Start 1 mask, 7 End 1 mask, 8 Start 2 mask, 9 End 2 mask. A write while enabled takes effect from the next period wrap. A write while disabled takes effect before the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global run enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | OFS_W (24) | Configuration write data |
| periph_en_o | output | N_PERIPH (8) | Peripheral enable vector |
| conv_trig_o | output | 1 | One-cycle conversion trigger |

## Verification
The bench sets E1 above E2. A design that kept the offset counter running after End 2 would clear the End 1 bit late, and the bench would see that bit fall. A run with S1 at zero and E2 at the last cycle of the period checks that the overlapping Start 1 is dropped. A design that restarted here would raise the Start 2 bits again in the second period. The bench writes one event mask partway through a period and checks that the old mask still applies until the period wrap, which catches a design that applies writes at once. A run with E1, S2 and E2 all equal catches a design where set beats clear on the same edge, and runs with non-zero prescale catch errors in event timing.

// File: rtl/pes_pkg.sv
`timescale 1ns/1ps
package pes_pkg;
  localparam int CFG_AW = 4;
  localparam int N_EVT  = 4;
  // event slots, also the order of time/mask registers
  localparam int EV_S1 = 0;
  localparam int EV_E1 = 1;
  localparam int EV_S2 = 2;
  localparam int EV_E2 = 3;
  // register map
  localparam int A_PRE       = 0;
  localparam int A_PER       = 1;
  localparam int A_TIME_BASE = 2;
  localparam int A_MASK_BASE = A_TIME_BASE + N_EVT;
endpackage

// File: rtl/pes_cfg_regs.sv
`timescale 1ns/1ps
module pes_cfg_regs
  import pes_pkg::*;
#(
  parameter int PRE_W    = 16,
  parameter int PER_W    = 16,
  parameter int OFS_W    = 24,
  parameter int N_PERIPH = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic                             we_i,
  input  logic [CFG_AW-1:0]                addr_i,
  input  logic [OFS_W-1:0]                 wdata_i,
  output logic [PRE_W-1:0]                 pre_o,
  output logic [PER_W-1:0]                 per_o,
  output logic [N_EVT-1:0][OFS_W-1:0]      time_o,
  output logic [N_EVT-1:0][N_PERIPH-1:0]   mask_o
);
  logic [PRE_W-1:0]               sh_pre;
  logic [PER_W-1:0]               sh_per;
  logic [N_EVT-1:0][OFS_W-1:0]    sh_time;
  logic [N_EVT-1:0][N_PERIPH-1:0] sh_mask;

  // staging copy, written by software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_pre  <= '0;
      sh_per  <= '0;
      sh_time <= '0;
      sh_mask <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_AW'(A_PRE)) sh_pre <= wdata_i[PRE_W-1:0];
      if (addr_i == CFG_AW'(A_PER)) sh_per <= wdata_i[PER_W-1:0];
      for (int e = 0; e < N_EVT; e++) begin
        if (addr_i == CFG_AW'(A_TIME_BASE + e)) sh_time[e] <= wdata_i;
        if (addr_i == CFG_AW'(A_MASK_BASE + e)) sh_mask[e] <= wdata_i[N_PERIPH-1:0];
      end
    end
  end

  // active copy, updated at period wrap or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_o  <= '0;
      per_o  <= '0;
      time_o <= '0;
      mask_o <= '0;
    end else if (load_i) begin
      pre_o  <= sh_pre;
      per_o  <= sh_per;
      time_o <= sh_time;
      mask_o <= sh_mask;
    end
  end
endmodule

// File: rtl/pes_period_tmr.sv
`timescale 1ns/1ps
module pes_period_tmr #(
  parameter int PRE_W = 16,
  parameter int PER_W = 16,
  parameter int OFS_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [OFS_W-1:0] s1_time_i,
  output logic [PRE_W-1:0] pre_cnt_o,
  output logic [PER_W-1:0] per_cnt_o,
  output logic             wrap_o,
  output logic             s1_hit_o
);
  logic tick;
  assign tick = (pre_cnt_o == prescale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_o <= '0;
      per_cnt_o <= '0;
    end else if (!en_i) begin
      pre_cnt_o <= '0;
      per_cnt_o <= '0;
    end else if (tick) begin
      pre_cnt_o <= '0;
      per_cnt_o <= (per_cnt_o == period_i) ? '0 : per_cnt_o + 1'b1;
    end else begin
      pre_cnt_o <= pre_cnt_o + 1'b1;
    end
  end

  assign wrap_o   = en_i && tick && (per_cnt_o == period_i);
  // one cycle per count value: first prescaler phase only
  assign s1_hit_o = en_i && (pre_cnt_o == '0) && (OFS_W'(per_cnt_o) == s1_time_i);
endmodule

// File: rtl/pes_offset_tmr.sv
`timescale 1ns/1ps
module pes_offset_tmr #(
  parameter int OFS_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  s1_hit_i,
  input  logic [2:0][OFS_W-1:0] cmp_i,    // 0:E1 1:S2 2:E2
  output logic                  run_o,
  output logic [OFS_W-1:0]      cnt_o,
  output logic                  s1_fire_o,
  output logic [2:0]            hit_o
);
  for (genvar g = 0; g < 3; g++) begin : g_cmp
    assign hit_o[g] = run_o && (cnt_o == cmp_i[g]);
  end

  // start match dropped while a sequence is still running
  assign s1_fire_o = s1_hit_i && !run_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      cnt_o <= '0;
    end else if (!en_i) begin
      run_o <= 1'b0;
      cnt_o <= '0;
    end else if (s1_fire_o) begin
      run_o <= 1'b1;
      cnt_o <= '0;
    end else if (run_o) begin
      if (hit_o[2]) begin
        run_o <= 1'b0;
        cnt_o <= '0;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_evt_sched.sv
`timescale 1ns/1ps
module pwr_evt_sched
  import pes_pkg::*;
#(
  parameter int PRE_W    = 16,
  parameter int PER_W    = 16,
  parameter int OFS_W    = 24,
  parameter int N_PERIPH = 8,
  parameter int ADCD_BIT = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [OFS_W-1:0]    cfg_wdata_i,
  output logic [N_PERIPH-1:0] periph_en_o,
  output logic                conv_trig_o
);
  logic [PRE_W-1:0]               act_pre;
  logic [PER_W-1:0]               act_per;
  logic [N_EVT-1:0][OFS_W-1:0]    act_time;
  logic [N_EVT-1:0][N_PERIPH-1:0] act_mask;
  logic [PRE_W-1:0]               pre_cnt;
  logic [PER_W-1:0]               per_cnt;
  logic                           per_wrap, s1_hit, cfg_load;
  logic                           ofs_run;
  logic [OFS_W-1:0]               ofs_cnt;
  logic                           s1_fire, e1_hit, s2_hit, e2_hit;
  logic [2:0]                     ofs_hit;
  logic [N_PERIPH-1:0]            set_m, clr_m;

  assign cfg_load = per_wrap || !en_i;

  pes_cfg_regs #(
    .PRE_W(PRE_W), .PER_W(PER_W), .OFS_W(OFS_W), .N_PERIPH(N_PERIPH)
  ) u_cfg (
    .clk_i, .rst_ni,
    .load_i (cfg_load),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .pre_o  (act_pre),
    .per_o  (act_per),
    .time_o (act_time),
    .mask_o (act_mask)
  );

  pes_period_tmr #(
    .PRE_W(PRE_W), .PER_W(PER_W), .OFS_W(OFS_W)
  ) u_per (
    .clk_i, .rst_ni, .en_i,
    .prescale_i(act_pre),
    .period_i  (act_per),
    .s1_time_i (act_time[EV_S1]),
    .pre_cnt_o (pre_cnt),
    .per_cnt_o (per_cnt),
    .wrap_o    (per_wrap),
    .s1_hit_o  (s1_hit)
  );

  pes_offset_tmr #(
    .OFS_W(OFS_W)
  ) u_ofs (
    .clk_i, .rst_ni, .en_i,
    .s1_hit_i (s1_hit),
    .cmp_i    ({act_time[EV_E2], act_time[EV_S2], act_time[EV_E1]}),
    .run_o    (ofs_run),
    .cnt_o    (ofs_cnt),
    .s1_fire_o(s1_fire),
    .hit_o    (ofs_hit)
  );

  assign e1_hit = ofs_hit[0];
  assign s2_hit = ofs_hit[1];
  assign e2_hit = ofs_hit[2];

  assign set_m = ({N_PERIPH{s1_fire}} & act_mask[EV_S1])
               | ({N_PERIPH{s2_hit}}  & act_mask[EV_S2]);
  assign clr_m = ({N_PERIPH{e1_hit}}  & act_mask[EV_E1])
               | ({N_PERIPH{e2_hit}}  & act_mask[EV_E2]);

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      periph_en_o <= '0;
      conv_trig_o <= 1'b0;
    end else if (!en_i) begin
      periph_en_o <= '0;
      conv_trig_o <= 1'b0;
    end else begin
      periph_en_o <= (periph_en_o | set_m) & ~clr_m;
      conv_trig_o <= set_m[ADCD_BIT];
    end
  end
endmodule

// File: rtl/pes_chk.sv
`timescale 1ns/1ps
module pes_chk #(
  parameter int PRE_W    = 16,
  parameter int PER_W    = 16,
  parameter int OFS_W    = 24,
  parameter int N_PERIPH = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic [N_PERIPH-1:0] periph_en_o,
  input logic                conv_trig_o,
  input logic [PRE_W-1:0]    pre_cnt,
  input logic [PRE_W-1:0]    act_pre,
  input logic [PER_W-1:0]    per_cnt,
  input logic                ofs_run,
  input logic [OFS_W-1:0]    ofs_cnt,
  input logic                s1_fire,
  input logic                e1_hit,
  input logic                s2_hit,
  input logic                e2_hit
);
  p_idle_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (periph_en_o == '0) && !conv_trig_o);

  p_prescale_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (pre_cnt != act_pre)) ##1 en_i |-> $stable(per_cnt));

  p_s1_starts_ofs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && s1_fire) ##1 en_i |-> ofs_run && (ofs_cnt == '0));

  p_ofs_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ofs_run && !e2_hit) ##1 en_i |-> ofs_cnt == OFS_W'($past(ofs_cnt) + 1'b1));

  p_quiet_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !(s1_fire || e1_hit || s2_hit || e2_hit) |=> $stable(periph_en_o));

  p_e2_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e2_hit |=> !ofs_run && (ofs_cnt == '0));

  p_trig_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_trig_o |-> $past(s1_fire || s2_hit));
endmodule

bind pwr_evt_sched pes_chk #(
  .PRE_W(PRE_W), .PER_W(PER_W), .OFS_W(OFS_W), .N_PERIPH(N_PERIPH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .periph_en_o(periph_en_o), .conv_trig_o(conv_trig_o),
  .pre_cnt(pre_cnt), .act_pre(act_pre), .per_cnt(per_cnt),
  .ofs_run(ofs_run), .ofs_cnt(ofs_cnt),
  .s1_fire(s1_fire), .e1_hit(e1_hit), .s2_hit(s2_hit), .e2_hit(e2_hit)
);

// File: tb/sim_pwr_evt_sched.sv
`timescale 1ns/1ps
module sim_pwr_evt_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [7:0]  pen;
  logic        trig;

  int n_chk = 0;
  int n_fail = 0;
  int edge_n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_evt_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .periph_en_o(pen), .conv_trig_o(trig)
  );

  task automatic chk(string req, logic [7:0] exp_en, logic exp_trig);
    n_chk++;
    if (pen !== exp_en || trig !== exp_trig) begin
      n_fail++;
      $display("FAIL %s edge %0d: en=%h trig=%b expected en=%h trig=%b",
               req, edge_n, pen, trig, exp_en, exp_trig);
    end
  endtask

  task automatic go(int n);
    while (edge_n < n) begin
      @(posedge clk);
      @(negedge clk);
      edge_n++;
    end
  endtask

  task automatic wr(int a, int d);
    we = 1'b1; addr = 4'(a); wdata = 24'(d);
    @(posedge clk); @(negedge clk);
    edge_n++;
    we = 1'b0;
  endtask

  task automatic setup(int pre, int per, int s1, int e1, int s2, int e2,
                       int ms1, int me1, int ms2, int me2);
    wr(0, pre); wr(1, per);
    wr(2, s1); wr(3, e1); wr(4, s2); wr(5, e2);
    wr(6, ms1); wr(7, me1); wr(8, ms2); wr(9, me2);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic start_run();
    en = 1'b1;
    edge_n = 0;
  endtask

  task automatic stop_run(string req);
    en = 1'b0;
    go(edge_n + 1);
    chk(req, 8'h00, 1'b0);
    go(edge_n + 2);
  endtask

  // R3 R4 R5 R9 R10 R2 R1
  task automatic t_basic();
    setup(1, 9, 2, 3, 5, 8, 'h41, 'h01, 'h82, 'hC2);
    start_run();
    go(4);  chk("R3 before S1", 8'h00, 1'b0);
    go(5);  chk("R3 S1 sets", 8'h41, 1'b0);
    wr(8, 'h04);  // R10 staged mask, edge 6
    go(9);  chk("R4 E1 clears", 8'h40, 1'b0);
    go(10); chk("R4 hold", 8'h40, 1'b0);
    go(11); chk("R10 old S2 mask with R9 trigger", 8'hC2, 1'b1);
    go(12); chk("R9 trigger one cycle", 8'hC2, 1'b0);
    go(14); chk("R5 E2 clears", 8'h00, 1'b0);
    go(24); chk("R2 before next period", 8'h00, 1'b0);
    go(25); chk("R2 next period S1", 8'h41, 1'b0);
    go(31); chk("R10 new S2 mask", 8'h44, 1'b0);
    go(34); chk("R5 E2 second period", 8'h04, 1'b0);
    stop_run("R1 disable clears");
  endtask

  // R6
  task automatic t_skip();
    setup(1, 9, 0, 10, 2, 4, 'h03, 'h01, 'h04, 'h02);
    start_run();
    go(1);  chk("R3 S1 at zero", 8'h03, 1'b0);
    go(4);  chk("R4 S2", 8'h07, 1'b0);
    go(7);  chk("R6 E2", 8'h05, 1'b0);
    go(19); chk("R6 E1 beyond E2 skipped", 8'h05, 1'b0);
    go(21); chk("R6 next S1", 8'h07, 1'b0);
    stop_run("R1 disable clears");
  endtask

  // R5 R7
  task automatic t_same_edge();
    setup(1, 9, 1, 3, 3, 3, 'h0F, 'h01, 'h10, 'h10);
    start_run();
    go(3); chk("R3 S1", 8'h0F, 1'b0);
    go(6); chk("R7 before", 8'h0F, 1'b0);
    go(7); chk("R7 R5 clear wins", 8'h0E, 1'b0);
    stop_run("R1 disable clears");
  endtask

  // R8
  task automatic t_overlap();
    setup(1, 4, 0, 0, 2, 9, 'h01, 'h00, 'h20, 'h21);
    start_run();
    go(1);  chk("R8 S1", 8'h01, 1'b0);
    go(4);  chk("R8 S2", 8'h21, 1'b0);
    go(10); chk("R8 hold", 8'h21, 1'b0);
    go(11); chk("R8 E2 while S1 dropped", 8'h00, 1'b0);
    go(14); chk("R8 S2 skipped", 8'h00, 1'b0);
    go(21); chk("R8 third period S1", 8'h01, 1'b0);
    stop_run("R1 disable clears");
  endtask

  // R2 R9 R4
  task automatic t_prescale();
    setup(2, 5, 2, 100, 100, 0, 'hC0, 'h00, 'h00, 'hC0);
    start_run();
    go(6);  chk("R2 prescaled before S1", 8'h00, 1'b0);
    go(7);  chk("R9 S1 with ADCD", 8'hC0, 1'b1);
    go(8);  chk("R4 E2 at zero", 8'h00, 1'b0);
    go(24); chk("R2 period 18", 8'h00, 1'b0);
    go(25); chk("R2 R9 next period", 8'hC0, 1'b1);
    stop_run("R1 disable clears");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_skip();
    t_same_edge();
    t_overlap();
    t_prescale();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule